// File: doc/BRIEF.md
# Bit-Serial Rotating Drum Store

This block models a memory laid out like a spinning magnetic drum. The drum has 32 circular tracks, and each track holds 32 word slots of 32 bits, so it stores 1024 words under a 10-bit address. A free-running head position moves forward by one bit every clock. It moves on to the next word slot after the last bit of a slot, and after the last slot it returns to slot 0. The head position is the same for every track.

A client raises `req` for one cycle with an address and a direction. The block then waits until the addressed slot comes round to the head at a word boundary. It moves the word across a 1-bit bus over the next 32 cycles, least significant bit first. Because of this, access latency depends on where the drum stands when the request arrives. The latency can be a single cycle, or a full revolution of 1024 cycles.

Top module: `drum_memory`

## Requirements
- R1: Address bits [9:5] select the track and bits [4:0] select the word slot. All 1024 addresses hold independent words, so a write to one track leaves the same slot on every other track unchanged.
- R2: In the first cycle after reset is released, the head is at slot 0, bit 0. The bit position advances every cycle. The slot advances after bit 31 and wraps from 31 to 0. This gives slot = (n/32) mod 32 and bit = n mod 32 in cycle n after release.
- R3: A request accepted in cycle c transfers in cycles d to d+31. Here d is the first cycle after c with bit 0 and slot equal to the requested slot, that is d − c = (32 − c mod 32) + 32·((slot − s′) mod 32), where s′ is the slot after the one under the head in cycle c. A request made at bit 0 of its own slot therefore waits 1024 cycles.
- R4: During a write transfer, the `din` value in cycle d+k becomes bit k of the addressed word, for k = 0 to 31. No other word changes.
- R5: During a read transfer, `dout` in cycle d+k carries bit k of the stored word. Reading does not change the stored word.
- R6: `dout` is 0 in every cycle outside a read transfer, including the cycles of a write transfer.
- R7: `busy` is 0 during reset and while idle. It is 1 from the cycle after an accepted request through cycle d+31, and 0 again in cycle d+32.
- R8: `word_valid` is 1 for exactly one cycle per transfer, in cycle d+31, and 0 in all other cycles.
- R9: A request raised while `busy` is 1 is ignored. It changes no stored word and does not alter the timing of the transfer in progress.
- R10: A request raised in the first cycle after `busy` falls is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | One-cycle access request, taken only when not busy |
| we | input | 1 | 1 = write, 0 = read, sampled with `req` |
| addr | input | 10 | Word address: track in [9:5], slot in [4:0] |
| din | input | 1 | Serial write data, one bit per transfer cycle |
| dout | output | 1 | Serial read data, 0 outside read transfers |
| busy | output | 1 | Request pending or transfer in progress |
| word_valid | output | 1 | Marks the last bit cycle of a transfer |

## Verification
The bench keeps a cycle count from reset release, so for any request cycle c it can work out the head position and the start cycle d from R2 and R3. `busy` is expected one cycle after c, and the 32 bits are expected in cycles d through d+31. `word_valid` is expected in cycle d+31, and `busy` is expected to fall in cycle d+32. Every output is sampled on the falling edge and compared against that prediction in every cycle, so a transfer that starts one cycle early or late shows up in the `busy` or `word_valid` comparison. Requests are placed at chosen head phases to produce the one-cycle minimum latency, the full-revolution maximum, and back-to-back acceptance.

// File: rtl/drum_pkg.sv
package drum_pkg;

  typedef enum logic [1:0] {
    HD_IDLE,
    HD_WAIT,
    HD_XFER
  } head_state_e;

  // Cycles from the request cycle to the first bit of the target slot.
  function automatic int unsigned start_delay(input int unsigned cur_bit,
                                              input int unsigned cur_slot,
                                              input int unsigned tgt_slot,
                                              input int unsigned bits,
                                              input int unsigned slots);
    int unsigned next_slot;
    next_slot = (cur_slot + 1) % slots;
    return (bits - cur_bit) + ((tgt_slot + slots - next_slot) % slots) * bits;
  endfunction

endpackage

// File: rtl/drum_rotor.sv
module drum_rotor #(
  parameter int SLOTS     = 32,
  parameter int WORD_BITS = 32,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int BIT_W    = $clog2(WORD_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              slot_end
);

  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_BITS - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  assign slot_end = (bit_idx == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx  <= '0;
      slot_idx <= '0;
    end else if (slot_end) begin
      bit_idx  <= '0;
      slot_idx <= (slot_idx == SLOT_LAST) ? '0 : slot_idx + 1'b1;
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> (bit_idx == $past(bit_idx) + 1'b1));

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end |=> $stable(slot_idx));

  // R2
  slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && slot_idx == SLOT_LAST) |=> (slot_idx == '0 && bit_idx == '0));

endmodule

// File: rtl/drum_sequencer.sv
module drum_sequencer
  import drum_pkg::*;
#(
  parameter int TRACKS    = 32,
  parameter int SLOTS     = 32,
  parameter int WORD_BITS = 32,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int TRACK_W  = $clog2(TRACKS),
  localparam int BIT_W    = $clog2(WORD_BITS),
  localparam int ADDR_W   = TRACK_W + SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BIT_W-1:0]   bit_idx,
  input  logic [SLOT_W-1:0]  slot_idx,
  input  logic               slot_end,
  output logic               busy,
  output logic               xfer_active,
  output logic               xfer_we,
  output logic               word_done,
  output logic [TRACK_W-1:0] tgt_track
);

  head_state_e       state, state_nx;
  logic [SLOT_W-1:0] tgt_slot;
  logic              accept;
  logic              at_start;

  assign accept      = (state == HD_IDLE) && req;
  assign at_start    = (state == HD_WAIT) && (slot_idx == tgt_slot) && (bit_idx == '0);
  assign xfer_active = at_start || (state == HD_XFER);
  assign word_done   = xfer_active && slot_end;
  assign busy        = (state != HD_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      HD_IDLE: if (accept)   state_nx = HD_WAIT;
      HD_WAIT: if (at_start) state_nx = HD_XFER;
      HD_XFER: if (slot_end) state_nx = HD_IDLE;
      default: state_nx = HD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= HD_IDLE;
      tgt_slot  <= '0;
      tgt_track <= '0;
      xfer_we   <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) begin
        tgt_slot  <= addr[SLOT_W-1:0];
        tgt_track <= addr[ADDR_W-1:SLOT_W];
        xfer_we   <= we;
      end
    end
  end

  // Checker-side countdown to the predicted start cycle.
  int unsigned lat_left;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_left <= 0;
    end else if (accept) begin
      lat_left <= start_delay(32'(bit_idx), 32'(slot_idx), 32'(addr[SLOT_W-1:0]),
                              WORD_BITS, SLOTS) - 1;
    end else if (lat_left != 0) begin
      lat_left <= lat_left - 1;
    end
  end

  // R3
  start_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HD_WAIT) |-> (at_start == (lat_left == 0)));

  // R3
  xfer_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HD_XFER) |-> (slot_idx == tgt_slot));

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !busy);

  // R8
  done_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (state == HD_XFER && slot_idx == tgt_slot));

  // R9
  ignore_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> ($stable(tgt_slot) && $stable(tgt_track) && $stable(xfer_we)));

endmodule

// File: rtl/drum_tracks.sv
module drum_tracks #(
  parameter int TRACKS    = 32,
  parameter int SLOTS     = 32,
  parameter int WORD_BITS = 32,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int TRACK_W  = $clog2(TRACKS),
  localparam int BIT_W    = $clog2(WORD_BITS)
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic               wr_bit,
  input  logic [TRACK_W-1:0] track_sel,
  input  logic [SLOT_W-1:0]  slot_sel,
  input  logic [BIT_W-1:0]   bit_sel,
  output logic               rd_bit
);

  logic [TRACKS-1:0] track_rd;

  for (genvar t = 0; t < TRACKS; t++) begin : g_track
    logic [WORD_BITS-1:0] cells [SLOTS];
    logic                 hit;

    assign hit = wr_en && (track_sel == TRACK_W'(t));

    always_ff @(posedge clk) begin
      if (hit) cells[slot_sel][bit_sel] <= wr_bit;
    end

    assign track_rd[t] = cells[slot_sel][bit_sel];
  end

  assign rd_bit = track_rd[track_sel];

endmodule

// File: rtl/drum_memory.sv
module drum_memory #(
  parameter int TRACKS    = 32,
  parameter int SLOTS     = 32,
  parameter int WORD_BITS = 32,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int TRACK_W  = $clog2(TRACKS),
  localparam int BIT_W    = $clog2(WORD_BITS),
  localparam int ADDR_W   = TRACK_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic              dout,
  output logic              busy,
  output logic              word_valid
);

  logic [BIT_W-1:0]   bit_idx;
  logic [SLOT_W-1:0]  slot_idx;
  logic               slot_end;
  logic               xfer_active;
  logic               xfer_we;
  logic [TRACK_W-1:0] tgt_track;
  logic               rd_bit;
  logic               wr_en;

  drum_rotor #(
    .SLOTS     (SLOTS),
    .WORD_BITS (WORD_BITS)
  ) u_rotor (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_idx  (bit_idx),
    .slot_idx (slot_idx),
    .slot_end (slot_end)
  );

  drum_sequencer #(
    .TRACKS    (TRACKS),
    .SLOTS     (SLOTS),
    .WORD_BITS (WORD_BITS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .we          (we),
    .addr        (addr),
    .bit_idx     (bit_idx),
    .slot_idx    (slot_idx),
    .slot_end    (slot_end),
    .busy        (busy),
    .xfer_active (xfer_active),
    .xfer_we     (xfer_we),
    .word_done   (word_valid),
    .tgt_track   (tgt_track)
  );

  assign wr_en = xfer_active && xfer_we;

  drum_tracks #(
    .TRACKS    (TRACKS),
    .SLOTS     (SLOTS),
    .WORD_BITS (WORD_BITS)
  ) u_tracks (
    .clk       (clk),
    .wr_en     (wr_en),
    .wr_bit    (din),
    .track_sel (tgt_track),
    .slot_sel  (slot_idx),
    .bit_sel   (bit_idx),
    .rd_bit    (rd_bit)
  );

  assign dout = (xfer_active && !xfer_we) ? rd_bit : 1'b0;

  // R8
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> busy);

  // R6
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dout);

endmodule

// File: tb/test_drum_memory.sv
`timescale 1ns/1ps
module test_drum_memory;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       we = 1'b0;
  logic [9:0] addr = '0;
  logic       din = 1'b0;
  logic       dout, busy, word_valid;

  always #2 clk = ~clk;

  drum_memory i_drum_memory (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .din(din), .dout(dout), .busy(busy), .word_valid(word_valid)
  );

  typedef struct {
    int          c;
    int          d;
    bit          wr;
    logic [31:0] data;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] shadow [1024];
  logic [31:0] got;
  int          cyc;
  int          busy_until = -1;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", tag, what, cyc, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as transfers complete.
  always @(negedge clk) begin
    item_t f;
    bit    have, win, rd, e_busy, e_valid;
    int    k;
    if (rst_n && !finished) begin
      have = (sb.size() > 0);
      win = 1'b0; rd = 1'b0; k = 0; e_busy = 1'b0; e_valid = 1'b0;
      if (have) begin
        f       = sb[0];
        win     = (cyc >= f.d) && (cyc <= f.d + 31);
        k       = cyc - f.d;
        rd      = win && !f.wr;
        e_busy  = (cyc > f.c);
        e_valid = (cyc == f.d + 31);
      end
      din = (win && f.wr) ? f.data[k] : 1'b0;
      check(busy === e_busy, "R7", "busy", 32'(busy), 32'(e_busy));
      check(word_valid === e_valid, "R2 R3 R8", "word_valid", 32'(word_valid), 32'(e_valid));
      if (rd) got[k] = dout;
      else check(dout === 1'b0, "R6", "dout idle", 32'(dout), 32'd0);
      if (have && cyc == f.d + 31) begin
        if (!f.wr) check(got === f.data, f.tag, "read word", got, f.data);
        void'(sb.pop_front());
      end
    end
  end

  // Driver: predicts the transfer window and pushes the expected item.
  task automatic access(input logic [9:0] a, input bit w, input logic [31:0] dt,
                        input string tag, input int ph_bit = -1, input int ph_slot = -1);
    item_t it;
    int    d;
    @(negedge clk);
    while (cyc <= busy_until || (ph_bit >= 0 && cyc % 32 != ph_bit) ||
           (ph_slot >= 0 && (cyc / 32) % 32 != ph_slot))
      @(negedge clk);
    req = 1'b1; we = w; addr = a;
    d = cyc + 1;
    while (!(d % 32 == 0 && (d / 32) % 32 == int'(a[4:0]))) d++;
    it.c = cyc; it.d = d; it.wr = w; it.tag = tag;
    it.data = w ? dt : shadow[a];
    if (w) shadow[a] = dt;
    sb.push_back(it);
    busy_until = d + 31;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // A request raised while busy; nothing is expected from it.
  task automatic poke(input logic [9:0] a, input bit w);
    req = 1'b1; we = w; addr = a;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R7", "busy in reset", 32'(busy), 32'd0);
    check(word_valid === 1'b0, "R8", "valid in reset", 32'(word_valid), 32'd0);
    check(dout === 1'b0, "R6", "dout in reset", 32'(dout), 32'd0);
    rst_n = 1'b1;

    access(10'h000, 1'b1, 32'hA5C3_0F81, "R4");
    access(10'h000, 1'b0, '0, "R4 R5");
    // minimum latency: request at bit 31 of the slot before the target
    access(10'h3FF, 1'b1, 32'h1234_5678, "R3", 31, 30);
    // full revolution: request at bit 0 of the target slot
    access(10'h3FF, 1'b0, '0, "R3", 0, 31);
    // same slot, other track
    access(10'h01F, 1'b1, 32'hDEAD_BEEF, "R1");
    access(10'h3FF, 1'b0, '0, "R1");
    access(10'h01F, 1'b0, '0, "R1");
    // ignored request while busy
    access(10'h0A6, 1'b1, 32'h0F0F_00FF, "R9");
    access(10'h0A5, 1'b1, 32'h8000_0001, "R9");
    poke(10'h0A6, 1'b1);
    poke(10'h3FF, 1'b0);
    access(10'h0A6, 1'b0, '0, "R9");
    access(10'h0A5, 1'b0, '0, "R9");
    // back-to-back acceptance in the first idle cycle
    access(10'h045, 1'b1, 32'h7654_3210, "R10");
    access(10'h045, 1'b0, '0, "R10");
    access(10'h000, 1'b0, '0, "R5");
    for (int i = 0; i < 6; i++) begin
      logic [9:0]  a;
      logic [31:0] v;
      a = 10'((i * 337 + 91) % 1024);
      v = (32'h9E37_79B9 * 32'(i + 1)) ^ 32'h5555_0000;
      access(a, 1'b1, v, "R4");
      access(a, 1'b0, '0, "R4 R5");
    end
    access(10'h000, 1'b0, '0, "R1 R5");

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule